// File: doc/BRIEF.md
# Paged Direct Address Former with Remappable RAM

This block turns a page pointer and a short instruction offset into a full data-memory address. It then steers data-port and program-port accesses onto three small on-chip RAM blocks. The page pointer is loaded by command. The resolved address is the page times 128 plus the 7-bit offset, so a 9-bit page reaches every word of a 64K-word space.

One RAM block can move between the two spaces under a configuration input. With the input low it serves data addresses from 200h, and the program port cannot see it. With the input high it serves program addresses from FF00h, and the data port cannot see it. Its contents stay in place across the switch, so words written through one space can be read through the other. A second block at data 300h and a scratch block at data 060h stay in data space whatever the configuration holds.

A move request copies the word at the current direct address to the next higher address. An access that lands in no block reads as zero and raises a per-port flag.

Top module: `paged_ram_map`

## Requirements
- R1: Reset clears the page pointer to 0. A page load takes effect from the cycle after the load command, and the address in the load cycle still uses the old page.
- R2: `phys_addr` equals page × 128 + offset, 16 bits wide, and follows the offset input in the same cycle.
- R3: With `remap` low, the movable block answers data addresses 200h up to 200h+MOV_WORDS−1. Program-port reads and writes are then unmapped and leave that block unchanged.
- R4: With `remap` high, the movable block answers program addresses FF00h up to FF00h+MOV_WORDS−1, and data accesses to its 200h window are unmapped. Offset i in either window selects the same physical word, so contents carry across a toggle in both directions.
- R5: The fixed block (data 300h, FIX_WORDS words) and the scratch block (data 060h, SCR_WORDS words) respond to the data port for either value of `remap`. Each data address hits at most one block.
- R6: A move request at direct address A writes the word held at A into A+1 on the following clock edge. If A is unmapped, zero is written. If A+1 is unmapped, nothing is written.
- R7: A read that hits no block returns zero on the port's read data in the next cycle. Any read or write that hits no block raises that port's unmapped flag in the next cycle, and an unmapped write changes no stored word.
- R8: Read data appears on the cycle after the request. A read issued the cycle after a write to the same word returns the new value. A read and a write of the same word in one cycle return the old value.
- R9: In the cycle a move completes its write, a data-port write request is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| page_ld | input | 1 | Load the page pointer |
| page_val | input | PAGE_W | Page value to load |
| dofs | input | OFS_W | Direct offset within the page |
| remap | input | 1 | High: movable block lives in program space |
| d_rd | input | 1 | Data-port read at the direct address |
| d_wr | input | 1 | Data-port write at the direct address |
| d_wdata | input | DATA_W | Data-port write word |
| mv_req | input | 1 | Copy word at direct address to the next address |
| p_rd | input | 1 | Program-port read |
| p_wr | input | 1 | Program-port write |
| p_addr | input | PAGE_W+OFS_W | Program-port address |
| p_wdata | input | DATA_W | Program-port write word |
| phys_addr | output | PAGE_W+OFS_W | Resolved direct address |
| d_rdata | output | DATA_W | Data-port read word |
| d_unmapped | output | 1 | Previous data access hit no block |
| p_rdata | output | DATA_W | Program-port read word |
| p_unmapped | output | 1 | Previous program access hit no block |

## Verification
The bench builds the block with MOV_WORDS=16, FIX_WORDS=16 and SCR_WORDS=8, keeping the default bases. With these sizes it can write and read back every stored word, together with several addresses on each side of every window, in both `remap` settings. The short windows also put the last word of a block and the first address past it within a few sweep steps. That lets moves be checked in the cases where the source or the destination falls outside any block.

// File: rtl/pram_pkg.sv
package pram_pkg;

  // Direct address: page shifted above the offset field.
  function automatic logic [31:0] direct_addr(input logic [31:0] page,
                                              input logic [31:0] ofs,
                                              input int unsigned ofs_w);
    return (page << ofs_w) | ofs;
  endfunction

  // True when addr lies in [base, base+words).
  function automatic logic in_win(input logic [31:0] addr,
                                  input logic [31:0] base,
                                  input logic [31:0] words);
    return (addr >= base) && (addr < base + words);
  endfunction

endpackage

// File: rtl/pram_page_ptr.sv
module pram_page_ptr #(
  parameter int unsigned PAGE_W = 9,
  parameter int unsigned OFS_W  = 7,
  localparam int unsigned ADDR_W = PAGE_W + OFS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              page_ld,
  input  logic [PAGE_W-1:0] page_val,
  input  logic [OFS_W-1:0]  dofs,
  output logic [ADDR_W-1:0] addr
);

  logic [PAGE_W-1:0] page_q;

  always_ff @(posedge clk) begin
    if (!rst_n)       page_q <= '0;
    else if (page_ld) page_q <= page_val;
  end

  assign addr = ADDR_W'(pram_pkg::direct_addr(32'(page_q), 32'(dofs), OFS_W));

  AST_PAGE_TAKES_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    page_ld |=> addr[ADDR_W-1:OFS_W] == $past(page_val)); // R1

endmodule

// File: rtl/pram_window.sv
module pram_window #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned IW     = 8,
  parameter int unsigned DBASE  = 'h200,
  parameter int unsigned PBASE  = 'hFF00,
  parameter int unsigned WORDS  = 256,
  parameter bit          MOVES  = 1'b0
) (
  input  logic              remap,
  input  logic [ADDR_W-1:0] d_addr,
  input  logic [ADDR_W-1:0] m_addr,
  input  logic [ADDR_W-1:0] p_addr,
  output logic              d_hit,
  output logic              m_hit,
  output logic              p_hit,
  output logic [IW-1:0]     d_idx,
  output logic [IW-1:0]     m_idx,
  output logic [IW-1:0]     p_idx
);

  logic in_prog;
  assign in_prog = MOVES && remap;

  assign d_hit = !in_prog && pram_pkg::in_win(32'(d_addr), DBASE, WORDS);
  assign m_hit = !in_prog && pram_pkg::in_win(32'(m_addr), DBASE, WORDS);
  assign p_hit =  in_prog && pram_pkg::in_win(32'(p_addr), PBASE, WORDS);

  assign d_idx = IW'(d_addr - ADDR_W'(DBASE));
  assign m_idx = IW'(m_addr - ADDR_W'(DBASE));
  assign p_idx = IW'(p_addr - ADDR_W'(PBASE));

endmodule

// File: rtl/pram_bank.sv
module pram_bank #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned WORDS  = 32,
  parameter int unsigned IW     = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [IW-1:0]     widx,
  input  logic [DATA_W-1:0] wdata,
  input  logic [IW-1:0]     ridx,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (we) mem[widx] <= wdata;
    rdata <= mem[ridx];
  end

  AST_WRITE_THEN_READ: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(we) && ridx == $past(widx)) |=> rdata == $past(wdata, 2)); // R8

endmodule

// File: rtl/paged_ram_map.sv
module paged_ram_map #(
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned PAGE_W    = 9,
  parameter int unsigned OFS_W     = 7,
  parameter int unsigned MOV_DBASE = 'h200,
  parameter int unsigned MOV_PBASE = 'hFF00,
  parameter int unsigned MOV_WORDS = 256,
  parameter int unsigned FIX_BASE  = 'h300,
  parameter int unsigned FIX_WORDS = 256,
  parameter int unsigned SCR_BASE  = 'h60,
  parameter int unsigned SCR_WORDS = 32,
  localparam int unsigned ADDR_W   = PAGE_W + OFS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              page_ld,
  input  logic [PAGE_W-1:0] page_val,
  input  logic [OFS_W-1:0]  dofs,
  input  logic              remap,
  input  logic              d_rd,
  input  logic              d_wr,
  input  logic [DATA_W-1:0] d_wdata,
  input  logic              mv_req,
  input  logic              p_rd,
  input  logic              p_wr,
  input  logic [ADDR_W-1:0] p_addr,
  input  logic [DATA_W-1:0] p_wdata,
  output logic [ADDR_W-1:0] phys_addr,
  output logic [DATA_W-1:0] d_rdata,
  output logic              d_unmapped,
  output logic [DATA_W-1:0] p_rdata,
  output logic              p_unmapped
);

  localparam int NBANK = 3;
  localparam int unsigned WIN_DBASE [NBANK] = '{MOV_DBASE, FIX_BASE, SCR_BASE};
  localparam int unsigned WIN_PBASE [NBANK] = '{MOV_PBASE, 0, 0};
  localparam int unsigned WIN_WORDS [NBANK] = '{MOV_WORDS, FIX_WORDS, SCR_WORDS};
  localparam bit          WIN_MOVES [NBANK] = '{1'b1, 1'b0, 1'b0};

  logic [ADDR_W-1:0] dir_addr;
  logic [ADDR_W-1:0] mv_dst;
  logic              mv_pend;
  logic [NBANK-1:0]  d_hit_v, m_hit_v, p_hit_v;
  logic [NBANK-1:0]  rd_sel_q, prd_sel_q, mv_src_q;
  logic [DATA_W-1:0] bank_q [NBANK];
  logic [DATA_W-1:0] mv_word;

  pram_page_ptr #(.PAGE_W(PAGE_W), .OFS_W(OFS_W)) u_page (
    .clk(clk), .rst_n(rst_n), .page_ld(page_ld), .page_val(page_val),
    .dofs(dofs), .addr(dir_addr)
  );

  assign phys_addr = dir_addr;

  for (genvar g = 0; g < NBANK; g++) begin : g_bank
    localparam int unsigned IW = (WIN_WORDS[g] > 1) ? $clog2(WIN_WORDS[g]) : 1;
    logic [IW-1:0]     d_idx, m_idx, p_idx, w_idx, r_idx;
    logic              w_en;
    logic [DATA_W-1:0] w_dat;

    pram_window #(
      .ADDR_W(ADDR_W), .IW(IW), .DBASE(WIN_DBASE[g]), .PBASE(WIN_PBASE[g]),
      .WORDS(WIN_WORDS[g]), .MOVES(WIN_MOVES[g])
    ) u_win (
      .remap(remap), .d_addr(dir_addr), .m_addr(mv_dst), .p_addr(p_addr),
      .d_hit(d_hit_v[g]), .m_hit(m_hit_v[g]), .p_hit(p_hit_v[g]),
      .d_idx(d_idx), .m_idx(m_idx), .p_idx(p_idx)
    );

    // One write port per block: program side, then move completion, then data port.
    always_comb begin
      w_en  = 1'b0;
      w_idx = d_idx;
      w_dat = d_wdata;
      if (p_wr && p_hit_v[g]) begin
        w_en  = 1'b1;
        w_idx = p_idx;
        w_dat = p_wdata;
      end else if (mv_pend && m_hit_v[g]) begin
        w_en  = 1'b1;
        w_idx = m_idx;
        w_dat = mv_word;
      end else if (!mv_pend && d_wr && d_hit_v[g]) begin
        w_en  = 1'b1;
      end
      r_idx = (WIN_MOVES[g] && remap) ? p_idx : d_idx;
    end

    pram_bank #(.DATA_W(DATA_W), .WORDS(WIN_WORDS[g]), .IW(IW)) u_ram (
      .clk(clk), .rst_n(rst_n), .we(w_en), .widx(w_idx), .wdata(w_dat),
      .ridx(r_idx), .rdata(bank_q[g])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mv_pend    <= 1'b0;
      mv_dst     <= '0;
      mv_src_q   <= '0;
      rd_sel_q   <= '0;
      prd_sel_q  <= '0;
      d_unmapped <= 1'b0;
      p_unmapped <= 1'b0;
    end else begin
      mv_pend    <= mv_req;
      mv_dst     <= dir_addr + ADDR_W'(1);
      mv_src_q   <= mv_req ? d_hit_v : '0;
      rd_sel_q   <= d_rd ? d_hit_v : '0;
      prd_sel_q  <= p_rd ? p_hit_v : '0;
      d_unmapped <= (d_rd || d_wr) && !(|d_hit_v);
      p_unmapped <= (p_rd || p_wr) && !(|p_hit_v);
    end
  end

  always_comb begin
    d_rdata = '0;
    p_rdata = '0;
    mv_word = '0;
    for (int g = 0; g < NBANK; g++) begin
      if (rd_sel_q[g])  d_rdata = d_rdata | bank_q[g];
      if (prd_sel_q[g]) p_rdata = p_rdata | bank_q[g];
      if (mv_src_q[g])  mv_word = mv_word | bank_q[g];
    end
  end

  AST_PROG_NEEDS_REMAP: assert property (@(posedge clk) disable iff (!rst_n)
    (|p_hit_v) |-> remap); // R3
  AST_NO_DUAL_SPACE: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(d_hit_v & p_hit_v))); // R4
  AST_ONE_BANK_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(d_hit_v)); // R5
  AST_MOVE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    mv_req |=> (mv_pend && mv_dst == $past(phys_addr) + ADDR_W'(1))); // R6
  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    d_unmapped |-> d_rdata == '0); // R7
  AST_PROG_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    p_unmapped |-> p_rdata == '0); // R7

endmodule

// File: tb/paged_ram_map_bench.sv
`timescale 1ns/1ps
module paged_ram_map_bench;

  localparam int NW0 = 16;
  localparam int NW1 = 16;
  localparam int NW2 = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        page_ld = 1'b0;
  logic [8:0]  page_val = '0;
  logic [6:0]  dofs = '0;
  logic        remap = 1'b0;
  logic        d_rd = 1'b0, d_wr = 1'b0, mv_req = 1'b0;
  logic [15:0] d_wdata = '0;
  logic        p_rd = 1'b0, p_wr = 1'b0;
  logic [15:0] p_addr = '0, p_wdata = '0;
  logic [15:0] phys_addr, d_rdata, p_rdata;
  logic        d_unmapped, p_unmapped;

  int nchk = 0;
  int nerr = 0;
  logic [15:0] rm [3][16];

  always #10 clk = ~clk;

  paged_ram_map #(.MOV_WORDS(NW0), .FIX_WORDS(NW1), .SCR_WORDS(NW2)) u_paged_ram_map (
    .clk(clk), .rst_n(rst_n), .page_ld(page_ld), .page_val(page_val), .dofs(dofs),
    .remap(remap), .d_rd(d_rd), .d_wr(d_wr), .d_wdata(d_wdata), .mv_req(mv_req),
    .p_rd(p_rd), .p_wr(p_wr), .p_addr(p_addr), .p_wdata(p_wdata),
    .phys_addr(phys_addr), .d_rdata(d_rdata), .d_unmapped(d_unmapped),
    .p_rdata(p_rdata), .p_unmapped(p_unmapped)
  );

  function automatic int bank_at(input logic [15:0] a, input logic rmp, input logic prog);
    int ai;
    ai = int'(a);
    if (prog) return (rmp && ai >= 'hFF00 && ai < 'hFF00 + NW0) ? 0 : -1;
    if (!rmp && ai >= 'h200 && ai < 'h200 + NW0) return 0;
    if (ai >= 'h300 && ai < 'h300 + NW1) return 1;
    if (ai >= 'h60 && ai < 'h60 + NW2) return 2;
    return -1;
  endfunction

  function automatic int off_at(input logic [15:0] a, input int b, input logic prog);
    int base;
    base = (b == 0) ? (prog ? 'hFF00 : 'h200) : (b == 1) ? 'h300 : 'h60;
    return int'(a) - base;
  endfunction

  function automatic logic [15:0] model_rd(input logic [15:0] a, input logic prog);
    int b;
    b = bank_at(a, remap, prog);
    return (b < 0) ? 16'h0 : rm[b][off_at(a, b, prog)];
  endfunction

  task automatic model_wr(input logic [15:0] a, input logic prog, input logic [15:0] w);
    int b;
    b = bank_at(a, remap, prog);
    if (b >= 0) rm[b][off_at(a, b, prog)] = w;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic setpage(input logic [15:0] a);
    page_ld = 1'b1; page_val = a[15:7];
    @(negedge clk);
    page_ld = 1'b0; dofs = a[6:0];
  endtask

  task automatic dwr(input logic [15:0] a, input logic [15:0] w);
    setpage(a);
    d_wr = 1'b1; d_wdata = w;
    @(negedge clk);
    d_wr = 1'b0;
    model_wr(a, 1'b0, w);
    chk("R7 write flag", d_unmapped, bank_at(a, remap, 1'b0) < 0);
  endtask

  task automatic drd(input logic [15:0] a, input string tag);
    setpage(a);
    d_rd = 1'b1;
    @(negedge clk);
    d_rd = 1'b0;
    chk(tag, d_rdata, model_rd(a, 1'b0));
    chk("R7 data flag", d_unmapped, bank_at(a, remap, 1'b0) < 0);
  endtask

  task automatic pwr(input logic [15:0] a, input logic [15:0] w);
    p_wr = 1'b1; p_addr = a; p_wdata = w;
    @(negedge clk);
    p_wr = 1'b0;
    model_wr(a, 1'b1, w);
    chk("R7 prog write flag", p_unmapped, bank_at(a, remap, 1'b1) < 0);
  endtask

  task automatic prd(input logic [15:0] a, input string tag);
    p_rd = 1'b1; p_addr = a;
    @(negedge clk);
    p_rd = 1'b0;
    chk(tag, p_rdata, model_rd(a, 1'b1));
    chk("R7 prog flag", p_unmapped, bank_at(a, remap, 1'b1) < 0);
  endtask

  task automatic do_move(input logic [15:0] a);
    logic [15:0] v;
    setpage(a);
    mv_req = 1'b1;
    v = model_rd(a, 1'b0);
    @(negedge clk);
    mv_req = 1'b0;
    @(negedge clk);
    model_wr(a + 16'd1, 1'b0, v);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nerr++;
    nchk++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    logic [15:0] old;
    logic [15:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk("R1 reset addr", phys_addr, 0);
    chk("R1 reset rdata", d_rdata, 0);
    chk("R1 reset dflag", d_unmapped, 0);
    chk("R1 reset pflag", p_unmapped, 0);

    // R1: page takes effect only after the load edge
    page_ld = 1'b1; page_val = 9'h1A5; dofs = 7'h11;
    #1 chk("R1 old page in load cycle", phys_addr, 16'h0011);
    @(negedge clk); page_ld = 1'b0;
    chk("R1 new page after load", phys_addr, 16'hD291);

    // R2: page/offset arithmetic sweep
    foreach (page_val[i]) begin end
    for (int pi = 0; pi < 6; pi++) begin
      int pg;
      pg = (pi == 0) ? 0 : (pi == 1) ? 1 : (pi == 2) ? 4 : (pi == 3) ? 6 : (pi == 4) ? 'h155 : 'h1FF;
      page_ld = 1'b1; page_val = 9'(pg);
      @(negedge clk); page_ld = 1'b0;
      for (int o = 0; o < 128; o += 21) begin
        dofs = 7'(o);
        #1 chk("R2 direct address", phys_addr, 32'((pg * 128 + o) & 'hFFFF));
      end
    end

    // R3 R5 R7: write sweeps across and around each window, remap low
    remap = 1'b0;
    for (int a = 'h1FC; a < 'h214; a++) dwr(16'(a), 16'(a * 7 + 'h1234));
    for (int a = 'h2FC; a < 'h314; a++) dwr(16'(a), 16'(a * 5 + 'h0F0F));
    for (int a = 'h5C; a < 'h6C; a++)   dwr(16'(a), 16'(a * 3 + 'hA000));
    for (int a = 'h1FC; a < 'h214; a++) drd(16'(a), "R3 data window remap low");
    for (int a = 'h2FC; a < 'h314; a++) drd(16'(a), "R5 fixed block remap low");
    for (int a = 'h5C; a < 'h6C; a++)   drd(16'(a), "R5 scratch block remap low");

    // R3: program port is unmapped with remap low; writes there are lost
    for (int a = 'hFEFE; a < 'hFF12; a++) prd(16'(a), "R3 program unmapped");
    pwr(16'hFF05, 16'hBEEF);
    drd(16'h0205, "R3 program write ignored");

    // R4: remap high
    remap = 1'b1;
    for (int a = 'hFEFC; a < 'hFF14; a++) prd(16'(a), "R4 program sees data words");
    for (int a = 'h1FE; a < 'h212; a++)   drd(16'(a), "R4 data window unmapped");
    for (int a = 'h2FE; a < 'h312; a += 3) drd(16'(a), "R5 fixed block remap high");
    for (int a = 'h5E; a < 'h6A; a++)     drd(16'(a), "R5 scratch block remap high");
    for (int a = 'hFF00; a < 'hFF00 + NW0; a++) pwr(16'(a), 16'(a ^ 'h5A5A));
    dwr(16'h0203, 16'hDEAD);
    remap = 1'b0;
    for (int a = 'h200; a < 'h200 + NW0; a++) drd(16'(a), "R4 data sees program words");

    // R8: same-cycle read/write returns old; next-cycle read returns new
    setpage(16'h0303);
    old = model_rd(16'h0303, 1'b0);
    d_rd = 1'b1; d_wr = 1'b1; d_wdata = 16'h7E57;
    @(negedge clk);
    d_rd = 1'b0;
    chk("R8 read during write old value", d_rdata, old);
    model_wr(16'h0303, 1'b0, 16'h7E57);
    d_wdata = 16'h4242;
    @(negedge clk);
    d_wr = 1'b0; d_rd = 1'b1;
    model_wr(16'h0303, 1'b0, 16'h4242);
    @(negedge clk);
    d_rd = 1'b0;
    chk("R8 read after write new value", d_rdata, 16'h4242);

    // R6: moves inside a block, off the end, and from an unmapped source
    for (int a = 'h308; a < 'h30F; a++) do_move(16'(a));
    for (int a = 'h307; a < 'h310; a++) drd(16'(a), "R6 move within fixed block");
    do_move(16'h020F);
    drd(16'h020F, "R6 move source unchanged");
    drd(16'h0210, "R6 move to unmapped dropped");
    do_move(16'h01FF);
    drd(16'h0200, "R6 move from unmapped writes zero");
    drd(16'h0201, "R6 neighbour untouched");
    dwr(16'h0200, 16'h3C3C);
    remap = 1'b1;
    do_move(16'h01FF);
    prd(16'hFF00, "R6 move into remapped block dropped");
    remap = 1'b0;
    do_move(16'h0067);
    drd(16'h0067, "R6 scratch last word kept");
    drd(16'h0068, "R6 past scratch unmapped");

    // R9: data write in the move completion cycle is dropped
    old = model_rd(16'h0302, 1'b0);
    v = model_rd(16'h0300, 1'b0);
    setpage(16'h0300);
    mv_req = 1'b1;
    @(negedge clk);
    mv_req = 1'b0; d_wr = 1'b1; dofs = 7'h02; d_wdata = 16'hDEAD;
    @(negedge clk);
    d_wr = 1'b0;
    model_wr(16'h0301, 1'b0, v);
    drd(16'h0302, "R9 write during move dropped");
    chk("R9 expected old value kept", model_rd(16'h0302, 1'b0), old);
    drd(16'h0301, "R9 move still completed");

    // R7: unmapped write leaves nothing behind
    dwr(16'h0400, 16'h1111);
    drd(16'h0400, "R7 unmapped read zero");

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

endmodule